// File: doc/BRIEF.md
# Power Rail Enable Controller

This block drives the enable lines of five supply rails in a low-power chip: a buck converter, a system LDO, a core LDO, an I/O LDO and a retention LDO. On a wakeup request it starts the supplies that a 2-bit power mode selects. It always starts the core and I/O rails. It times each supply's startup with a cycle counter and signals completion with a one-cycle `wake_done` pulse. In the mode that starts both main supplies in parallel, it then drops the system LDO.

Between wakeups, software turns rails on and off with write-one strobes. A sleep request turns off the rails that are marked for turn-off-on-sleep. For each of the four controllable rails, an override pair can force the enable output to a fixed value regardless of the hardware state. A status register reads back what the rails actually receive. The retention rail has only a plain register bit, which is set after reset.

Register port: one write or read per cycle on `reg_addr`. Writes take effect at the clock edge. `reg_rdata` is a combinational read of the addressed register. Rail bit order in every 4-bit rail field: bit 0 buck, bit 1 system LDO, bit 2 core LDO, bit 3 I/O LDO.

Top module: `rail_enable_ctrl`

## Requirements
- R1: After reset the four hardware rail states are 0, the override enables are 0, the retention enable is 1, the power mode is 0 and `wake_done` is 0.
- R2: A `wake_req` sampled while no wakeup is running starts a wakeup. At that edge it turns on core and I/O, and also turns on buck for modes 0, 2 and 3 and the system LDO for modes 1, 2 and 3. The mode is register 0 bits [1:0].
- R3: `wake_done` is high for exactly one cycle. It rises N+1 clock edges after the edge that sampled the starting `wake_req`, where N is BUCK_CYC in mode 0, SYS_CYC in mode 1, and the larger of the two in modes 2 and 3.
- R4: In mode 2 the system LDO hardware state falls at the same edge that raises `wake_done`. In mode 3 it stays on.
- R5: A `wake_req` that arrives while a wakeup is running is ignored and does not change the completion time.
- R6: A write to register 1 sets the rails named in wdata[3:0] and clears the rails named in wdata[7:4]. Clear wins when both bits for a rail are 1. Register 1 reads as 0.
- R7: A `sleep_req` sampled with no wakeup running and no wakeup starting clears each rail whose bit in register 2 [3:0] is 1. Rails whose bit is 0 are unchanged.
- R8: A `sleep_req` that arrives during a wakeup, or in the cycle a wakeup starts, is held. It is applied at the first edge at which no wakeup is running or starting, which is never before `wake_done` has been high.
- R9: Register 3 [3:0] holds override values and register 4 [3:0] holds override enables. A rail whose override enable is 1 outputs its override value. Otherwise it outputs its hardware state.
- R10: Register 5 reads {retention enable, effective enables[3:0]}. Registers 0, 2, 3, 4 and 6 read back their stored bits zero-extended, and registers 5 and 7 ignore writes.
- R11: Register 6 bit 0 drives `ret_en`. Wakeup, sleep, strobes and overrides never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 5 | Read data of the addressed register |
| wake_req | input | 1 | Wakeup request |
| sleep_req | input | 1 | Sleep-entry request |
| wake_done | output | 1 | One-cycle pulse at wakeup completion |
| buck_en | output | 1 | Buck converter enable |
| sysldo_en | output | 1 | System LDO enable |
| core_en | output | 1 | Core LDO enable |
| io_en | output | 1 | I/O LDO enable |
| ret_en | output | 1 | Retention LDO enable |

## Verification
The hardest situation to reach is a sleep request that lands inside a running wakeup. The request must stay held through the completion pulse and then act one edge later, possibly on the same edge as a new wakeup request or a strobe. The directed part raises `sleep_req` in the middle of a wakeup and checks the rails in the completion cycle and in the cycle after it. The random part issues wakeup and sleep requests densely enough that they often overlap, and a cycle-level bench model checks every output on every cycle.

// File: rtl/rail_ctrl_pkg.sv
package rail_ctrl_pkg;
  localparam int NRAIL = 4;
  localparam int R_BUCK = 0;
  localparam int R_SYS  = 1;
  localparam int R_CORE = 2;
  localparam int R_IO   = 3;

  localparam logic [2:0] A_MODE   = 3'd0;
  localparam logic [2:0] A_STROBE = 3'd1;
  localparam logic [2:0] A_SLPOFF = 3'd2;
  localparam logic [2:0] A_OVAL   = 3'd3;
  localparam logic [2:0] A_OEN    = 3'd4;
  localparam logic [2:0] A_STAT   = 3'd5;
  localparam logic [2:0] A_RET    = 3'd6;

  localparam logic [1:0] M_DROP_SYS = 2'd2;

  typedef enum logic {SQ_IDLE, SQ_WAKE} seq_st_e;
endpackage

// File: rtl/rail_startup_timer.sv
module rail_startup_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (load_i) begin
      cnt_d  = val_i;
      cnt_ce = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rail_wake_seq.sv
module rail_wake_seq
  import rail_ctrl_pkg::*;
#(
  parameter int BUCK_CYC = 6000,
  parameter int SYS_CYC  = 2000,
  parameter int CW       = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_req_i,
  input  logic [1:0] mode_i,
  output logic       start_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       drop_sys_o,
  output logic       start_buck_o,
  output logic       start_sys_o
);
  seq_st_e    st_q, st_d;
  logic [1:0] mode_q;
  logic       done_q;
  logic       finish;
  logic [1:0] tmr_exp;
  logic [1:0] tmr_on;
  logic [CW-1:0] tmr_cyc [2];

  assign start_buck_o = (mode_i != 2'd1);
  assign start_sys_o  = (mode_i != 2'd0);
  assign start_o      = (st_q == SQ_IDLE) && wake_req_i;
  assign busy_o       = (st_q == SQ_WAKE);
  assign finish       = busy_o && (&tmr_exp);
  assign drop_sys_o   = finish && (mode_q == M_DROP_SYS);
  assign done_o       = done_q;

  assign tmr_on     = {start_sys_o, start_buck_o};
  assign tmr_cyc[0] = CW'(BUCK_CYC);
  assign tmr_cyc[1] = CW'(SYS_CYC);

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    rail_startup_timer #(.CW(CW)) tmr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_o),
      .val_i     (tmr_on[g] ? tmr_cyc[g] : '0),
      .expired_o (tmr_exp[g])
    );
  end

  always_comb begin
    st_d = st_q;
    if (start_o)     st_d = SQ_WAKE;
    else if (finish) st_d = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (start_o) mode_q <= mode_i;
  end
endmodule

// File: rtl/rail_ovr_mux.sv
module rail_ovr_mux #(
  parameter int N = 4
) (
  input  logic [N-1:0] hw_i,
  input  logic [N-1:0] oen_i,
  input  logic [N-1:0] oval_i,
  output logic [N-1:0] eff_o
);
  for (genvar i = 0; i < N; i++) begin : g_mux
    assign eff_o[i] = oen_i[i] ? oval_i[i] : hw_i[i];
  end
endmodule

// File: rtl/rail_enable_ctrl.sv
module rail_enable_ctrl
  import rail_ctrl_pkg::*;
#(
  parameter int BUCK_CYC = 6000,
  parameter int SYS_CYC  = 2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [2*NRAIL-1:0]   reg_wdata,
  output logic [NRAIL:0]       reg_rdata,
  input  logic                 wake_req,
  input  logic                 sleep_req,
  output logic                 wake_done,
  output logic                 buck_en,
  output logic                 sysldo_en,
  output logic                 core_en,
  output logic                 io_en,
  output logic                 ret_en
);
  localparam int CMAX = (BUCK_CYC > SYS_CYC) ? BUCK_CYC : SYS_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [1:0]       mode_q;
  logic [NRAIL-1:0] slp_q, oval_q, oen_q, hw_q, hw_d, eff;
  logic             ret_q, pend_q, pend_d;
  logic             seq_start, seq_busy, seq_drop, st_buck, st_sys;
  logic             sleep_apply;
  logic             wr_mode, wr_strb, wr_slp, wr_oval, wr_oen, wr_ret;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign wr_mode = reg_we && (reg_addr == A_MODE);
  assign wr_strb = reg_we && (reg_addr == A_STROBE);
  assign wr_slp  = reg_we && (reg_addr == A_SLPOFF);
  assign wr_oval = reg_we && (reg_addr == A_OVAL);
  assign wr_oen  = reg_we && (reg_addr == A_OEN);
  assign wr_ret  = reg_we && (reg_addr == A_RET);

  rail_wake_seq #(.BUCK_CYC(BUCK_CYC), .SYS_CYC(SYS_CYC), .CW(CW)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .wake_req_i   (wake_req),
    .mode_i       (mode_q),
    .start_o      (seq_start),
    .busy_o       (seq_busy),
    .done_o       (wake_done),
    .drop_sys_o   (seq_drop),
    .start_buck_o (st_buck),
    .start_sys_o  (st_sys)
  );

  assign sleep_apply = !seq_busy && !seq_start && (sleep_req || pend_q);

  always_comb begin
    hw_d = hw_q;
    if (seq_start) begin
      hw_d[R_CORE] = 1'b1;
      hw_d[R_IO]   = 1'b1;
      if (st_buck) hw_d[R_BUCK] = 1'b1;
      if (st_sys)  hw_d[R_SYS]  = 1'b1;
    end
    if (seq_drop)    hw_d[R_SYS] = 1'b0;
    if (sleep_apply) hw_d = hw_d & ~slp_q;
    if (wr_strb) begin
      hw_d = hw_d | reg_wdata[NRAIL-1:0];
      hw_d = hw_d & ~reg_wdata[2*NRAIL-1:NRAIL];
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (sleep_apply)    pend_d = 1'b0;
    else if (sleep_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hw_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      hw_q   <= hw_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= '0;
      slp_q  <= '0;
      oval_q <= '0;
      oen_q  <= '0;
      ret_q  <= 1'b1;
    end else begin
      if (wr_mode) mode_q <= reg_wdata[1:0];
      if (wr_slp)  slp_q  <= reg_wdata[NRAIL-1:0];
      if (wr_oval) oval_q <= reg_wdata[NRAIL-1:0];
      if (wr_oen)  oen_q  <= reg_wdata[NRAIL-1:0];
      if (wr_ret)  ret_q  <= reg_wdata[0];
    end
  end

  rail_ovr_mux #(.N(NRAIL)) mux_i (
    .hw_i   (hw_q),
    .oen_i  (oen_q),
    .oval_i (oval_q),
    .eff_o  (eff)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE:   reg_rdata = {{(NRAIL-1){1'b0}}, mode_q};
      A_SLPOFF: reg_rdata = {1'b0, slp_q};
      A_OVAL:   reg_rdata = {1'b0, oval_q};
      A_OEN:    reg_rdata = {1'b0, oen_q};
      A_STAT:   reg_rdata = {ret_q, eff};
      A_RET:    reg_rdata = {{NRAIL{1'b0}}, ret_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign buck_en   = eff[R_BUCK];
  assign sysldo_en = eff[R_SYS];
  assign core_en   = eff[R_CORE];
  assign io_en     = eff[R_IO];
  assign ret_en    = ret_q;
endmodule

// File: rtl/rail_enable_ctrl_chk.sv
module rail_enable_ctrl_chk (
  input logic       clk,
  input logic       rst_n_s,
  input logic       wake_done,
  input logic       wake_start,
  input logic       busy,
  input logic       reg_we,
  input logic       wr_ret,
  input logic       wr_oen,
  input logic       clr_buck,
  input logic       clr_core,
  input logic       sleep_req,
  input logic       wake_req,
  input logic [3:0] oen,
  input logic [3:0] slp,
  input logic       buck_en,
  input logic       sysldo_en,
  input logic       core_en,
  input logic       io_en,
  input logic       ret_en
);
  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    wake_done |=> !wake_done);

  // R2: a started wakeup turns on the core rail
  p_core_on_wake_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wake_start && !oen[2] && !wr_oen && !clr_core) |=> core_en);

  // R6: a clear strobe turns the buck rail off even with its set bit
  p_clr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clr_buck && !oen[0] && !wr_oen) |=> !buck_en);

  // R7: sleep clears a marked rail
  p_sleep_off_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sleep_req && !busy && !wake_req && slp[3] && !oen[3] && !reg_we) |=> !io_en);

  // R9: an overridden rail holds still without register writes
  p_ovr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (oen[1] && $past(oen[1]) && !$past(reg_we)) |-> $stable(sysldo_en));

  // R11: retention enable moves only on its own register write
  p_ret_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wr_ret |=> $stable(ret_en));
endmodule

bind rail_enable_ctrl rail_enable_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .wake_done  (wake_done),
  .wake_start (seq_start),
  .busy       (seq_busy),
  .reg_we     (reg_we),
  .wr_ret     (wr_ret),
  .wr_oen     (wr_oen),
  .clr_buck   (wr_strb && reg_wdata[4]),
  .clr_core   (wr_strb && reg_wdata[6]),
  .sleep_req  (sleep_req),
  .wake_req   (wake_req),
  .oen        (oen_q),
  .slp        (slp_q),
  .buck_en    (buck_en),
  .sysldo_en  (sysldo_en),
  .core_en    (core_en),
  .io_en      (io_en),
  .ret_en     (ret_en)
);

// File: tb/rail_enable_ctrl_tb_top.sv
module rail_enable_ctrl_tb_top;
  localparam int BUCK = 40;
  localparam int SYS  = 15;
  localparam int BIG  = (BUCK > SYS) ? BUCK : SYS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd5;
  logic [7:0] reg_wdata = 8'd0;
  logic [4:0] reg_rdata;
  logic       wake_req = 1'b0;
  logic       sleep_req = 1'b0;
  logic       wake_done;
  logic       buck_en, sysldo_en, core_en, io_en, ret_en;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rail_enable_ctrl #(.BUCK_CYC(BUCK), .SYS_CYC(SYS)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_req(wake_req),
    .sleep_req(sleep_req), .wake_done(wake_done), .buck_en(buck_en),
    .sysldo_en(sysldo_en), .core_en(core_en), .io_en(io_en), .ret_en(ret_en)
  );

  // bench reference state
  logic [1:0] m_mode = 2'd0, m_wmode = 2'd0;
  logic [3:0] m_slp = 4'd0, m_oval = 4'd0, m_oen = 4'd0, m_hw = 4'd0;
  logic       m_ret = 1'b1, m_busy = 1'b0, m_pend = 1'b0, m_done = 1'b0;
  int         m_left = 0;

  function automatic logic [4:0] exp_rails();
    return {m_ret, (m_oen & m_oval) | (~m_oen & m_hw)};
  endfunction

  function automatic logic [4:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {3'b0, m_mode};
      3'd2: return {1'b0, m_slp};
      3'd3: return {1'b0, m_oval};
      3'd4: return {1'b0, m_oen};
      3'd5: return exp_rails();
      3'd6: return {4'b0, m_ret};
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [4:0] act_rails();
    return {ret_en, io_en, core_en, sysldo_en, buck_en};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic we, input logic [2:0] a, input logic [7:0] wd,
                            input logic wk, input logic sl);
    logic [3:0] h;
    logic was_busy, st, fin;
    h = m_hw;
    was_busy = m_busy;
    st  = !was_busy && wk;
    fin = was_busy && (m_left == 0);
    if (st) begin
      m_wmode = m_mode;
      h = h | {2'b11, m_mode != 2'd0, m_mode != 2'd1};
      m_left = (m_mode == 2'd0) ? BUCK : (m_mode == 2'd1) ? SYS : BIG;
      m_busy = 1'b1;
    end else if (fin) begin
      m_busy = 1'b0;
      if (m_wmode == 2'd2) h[1] = 1'b0;
    end else if (was_busy) begin
      m_left--;
    end
    if (!was_busy && !st && (sl || m_pend)) begin
      h = h & ~m_slp;
      m_pend = 1'b0;
    end else if (sl) begin
      m_pend = 1'b1;
    end
    if (we && a == 3'd1) begin
      h = h | wd[3:0];
      h = h & ~wd[7:4];
    end
    m_hw = h;
    m_done = fin;
    if (we) begin
      case (a)
        3'd0: m_mode = wd[1:0];
        3'd2: m_slp  = wd[3:0];
        3'd3: m_oval = wd[3:0];
        3'd4: m_oen  = wd[3:0];
        3'd6: m_ret  = wd[0];
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] wd,
                      input logic wk, input logic sl);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd; wake_req = wk; sleep_req = sl;
    model_edge(we, a, wd, wk, sl);
    @(posedge clk);
    #1;
    chk("R9 rails", {3'b0, act_rails()}, {3'b0, exp_rails()});
    chk("R3 done", {7'b0, wake_done}, {7'b0, m_done});
    chk("R10 read", {3'b0, reg_rdata}, {3'b0, exp_read(a)});
  endtask

  task automatic idle();
    step(1'b0, 3'd5, 8'd0, 1'b0, 1'b0);
  endtask

  task automatic wake_run(input logic [1:0] mode, input int n_exp, input logic sys_after);
    int n;
    step(1'b1, 3'd0, {6'b0, mode}, 1'b0, 1'b0);
    step(1'b0, 3'd5, 8'd0, 1'b1, 1'b0);
    chk("R2 start rails", {3'b0, act_rails()},
        {3'b0, 1'b1, 2'b11, mode != 2'd0, mode != 2'd1});
    n = 0;
    for (int i = 0; i < 200; i++) begin
      idle();
      n++;
      if (wake_done) break;
    end
    chk("R3 done latency", 8'(n), 8'(n_exp + 1));
    chk("R4 sys after done", {7'b0, sysldo_en}, {7'b0, sys_after});
    idle();
    chk("R3 pulse width", {7'b0, wake_done}, 8'd0);
    step(1'b1, 3'd1, 8'hF0, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int nd;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();

    // R1: reset state
    chk("R1 rails", {3'b0, act_rails()}, 8'b0001_0000);
    chk("R1 done", {7'b0, wake_done}, 8'd0);
    step(1'b0, 3'd4, 8'd0, 1'b0, 1'b0);
    chk("R1 oen", {3'b0, reg_rdata}, 8'd0);
    step(1'b0, 3'd0, 8'd0, 1'b0, 1'b0);
    chk("R1 mode", {3'b0, reg_rdata}, 8'd0);

    // R2 R3 R4: each mode
    wake_run(2'd0, BUCK, 1'b0);
    wake_run(2'd1, SYS, 1'b1);
    wake_run(2'd2, BIG, 1'b0);
    wake_run(2'd3, BIG, 1'b1);

    // R5: repeated wake during a run does not move completion
    step(1'b1, 3'd0, 8'd0, 1'b0, 1'b0);
    step(1'b0, 3'd5, 8'd0, 1'b1, 1'b0);
    nd = 0;
    for (int i = 0; i < 200; i++) begin
      step(1'b0, 3'd5, 8'd0, (i == 10) || (i == 20), 1'b0);
      nd++;
      if (wake_done) break;
    end
    chk("R5 latency", 8'(nd), 8'(BUCK + 1));
    step(1'b1, 3'd1, 8'hF0, 1'b0, 1'b0);

    // R6: set and clear in one write, clear wins
    step(1'b1, 3'd1, 8'h3F, 1'b0, 1'b0);
    chk("R6 clear wins", {4'b0, act_rails() & 5'h0F}, 8'h0C);
    step(1'b0, 3'd1, 8'd0, 1'b0, 1'b0);
    chk("R6 strobe reads 0", {3'b0, reg_rdata}, 8'd0);

    // R7: sleep only clears marked rails
    step(1'b1, 3'd1, 8'h0F, 1'b0, 1'b0);
    step(1'b1, 3'd2, 8'h05, 1'b0, 1'b0);
    step(1'b0, 3'd5, 8'd0, 1'b0, 1'b1);
    chk("R7 sleep", {4'b0, act_rails() & 5'h0F}, 8'h0A);

    // R8: sleep inside wakeup is held until after done
    step(1'b1, 3'd2, 8'h0F, 1'b0, 1'b0);
    step(1'b1, 3'd0, 8'd3, 1'b0, 1'b0);
    step(1'b0, 3'd5, 8'd0, 1'b1, 1'b0);
    step(1'b0, 3'd5, 8'd0, 1'b0, 1'b1);
    for (int i = 0; i < 200; i++) begin
      idle();
      if (wake_done) break;
    end
    chk("R8 held at done", {4'b0, act_rails() & 5'h0F}, 8'h0F);
    idle();
    chk("R8 applied after", {4'b0, act_rails() & 5'h0F}, 8'h00);

    // R9: override forces values
    step(1'b1, 3'd3, 8'h02, 1'b0, 1'b0);
    step(1'b1, 3'd4, 8'h03, 1'b0, 1'b0);
    step(1'b1, 3'd1, 8'h0F, 1'b0, 1'b0);
    chk("R9 override", {4'b0, act_rails() & 5'h0F}, 8'h0E);
    step(1'b1, 3'd4, 8'h00, 1'b0, 1'b0);
    chk("R9 released", {4'b0, act_rails() & 5'h0F}, 8'h0F);

    // R10: status and ignored writes
    step(1'b1, 3'd5, 8'h00, 1'b0, 1'b0);
    chk("R10 status", {3'b0, reg_rdata}, 8'h1F);

    // R11: retention register only
    step(1'b1, 3'd6, 8'h00, 1'b0, 1'b0);
    chk("R11 ret off", {7'b0, ret_en}, 8'd0);
    step(1'b0, 3'd5, 8'd0, 1'b0, 1'b1);
    step(1'b1, 3'd1, 8'hFF, 1'b0, 1'b0);
    chk("R11 ret kept", {7'b0, ret_en}, 8'd0);
    step(1'b1, 3'd6, 8'h01, 1'b0, 1'b0);
    chk("R11 ret on", {7'b0, ret_en}, 8'd1);

    // random mix, all checked against the reference state
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [2:0] a;
      logic [7:0] wd;
      we = ($urandom % 100) < 30;
      a  = 3'($urandom % 8);
      wd = 8'($urandom);
      if (a == 3'd4) wd = wd & 8'h05;
      step(we, a, wd, ($urandom % 100) < 6, ($urandom % 100) < 6);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule